// File: doc/BRIEF.md
# Six-Channel Trigger Coincidence Evaluator

This block turns six already-conditioned trigger channels into one trigger decision. The decision comes from an arbitrary Boolean function of the six channel bits. Software converts a logic expression into a 64-entry truth table off-chip and hands that table word to the block. The block can then express any mix of required channels, vetoed channels and channels that are ignored, joined by AND, OR and NOT.

The six channel bits form an index into the table, and the table bit at that index is the coincidence result. A registered strobe, one clock wide, marks each rising transition of that result, so an overlap that lasts many cycles produces a single trigger. The table is loaded from its input word only on a write strobe, and loads take effect on a clock boundary. A 32-bit count records every strobe that has been emitted.

Top module: `trig_coinc_eval`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the strobe, the strobe count and the active table to all zeros, and clears the edge-tracking state.
- R2: The coincidence result is bit `ch_in[5:0]` of the active table, where `ch_in[0]` is channel 1 and `ch_in[5]` is channel 6, so the index is {CH6..CH1}.
- R3: `trig_out` rises at the clock edge that follows the first cycle in which the coincidence result is 1 after a cycle in which it was 0. It is high for exactly one cycle, even while the result stays 1, including when the index moves between two true entries.
- R4: While `enable` is low, `trig_out` stays 0 and the edge tracker is cleared. A coincidence that is held across a return of `enable` to high therefore fires once on the first enabled cycle.
- R5: The active table is replaced by `table_in` only at a rising edge where `table_wr` is high. The evaluation at that same edge still uses the old table. Changes of `table_in` without `table_wr` have no effect on `trig_out`.
- R6: `trig_count` increases by exactly one at each edge that raises `trig_out` and holds otherwise, so it always equals the number of strobes emitted since reset.
- R7: With the table for (CH1 AND NOT CH2) AND (CH3 OR CH4 OR CH5 OR CH6), a strobe occurs only for inputs with CH1 present, CH2 absent and at least one of CH3..CH6 present.
- R8: A channel that the table does not depend on (a don't-care) never changes the outcome. Toggling it alone neither creates nor suppresses a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Evaluation enable |
| ch_in | input | 6 | Conditioned channel levels, bit 0 = channel 1 |
| table_in | input | 64 | Truth table word to load |
| table_wr | input | 1 | Load strobe for the truth table |
| trig_out | output | 1 | One-cycle trigger strobe |
| trig_count | output | 32 | Number of strobes since reset |

## Verification
All 64 channel patterns are swept under several tables: the veto example, an all-channel AND, a single-channel table with five don't-cares and a parity table. Each pattern is preceded by an idle pattern so that each true entry produces a fresh edge. A Gray-code walk keeps the result high while the index changes. A design that fired on index changes, rather than on a rise of the result, would strobe there repeatedly. The bench reloads the table while a pattern is held and checks that the edge of the load still uses the old table. It also changes the table word without a load and checks that nothing follows; a design that read the input word directly would fire early there. Dropping `enable` during a held coincidence must suppress the strobe and then re-arm it. A design that kept the edge tracker would miss the trigger on re-enable.

// File: rtl/trig_coinc_eval.sv
module trig_coinc_eval #(
  parameter int NCH   = 6,
  parameter int CNT_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic [NCH-1:0]      ch_in,
  input  logic [(1<<NCH)-1:0] table_in,
  input  logic                table_wr,
  output logic                trig_out,
  output logic [CNT_W-1:0]    trig_count
);
  localparam int TBL_W = 1 << NCH;

  logic [TBL_W-1:0] tbl_q;
  logic             hit;
  logic             hit_q;
  logic             fire;

  assign hit  = tbl_q[ch_in];
  assign fire = enable & hit & ~hit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tbl_q      <= '0;
      hit_q      <= 1'b0;
      trig_out   <= 1'b0;
      trig_count <= '0;
    end else begin
      if (table_wr) tbl_q <= table_in;
      hit_q    <= enable & hit;
      trig_out <= fire;
      if (fire) trig_count <= trig_count + 1'b1;
    end
  end
endmodule

module trig_coinc_eval_chk #(
  parameter int NCH   = 6,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             trig_out,
  input logic [CNT_W-1:0] trig_count
);
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (!trig_out && trig_count == '0));
  p_single_cycle_r3: assert property (@(posedge clk) disable iff (rst) trig_out |=> !trig_out);
  p_enable_gate_r4: assert property (@(posedge clk) disable iff (rst) !enable |=> !trig_out);
  p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && trig_out) |-> trig_count == $past(trig_count) + 1'b1);
  p_count_hold_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !trig_out) |-> $stable(trig_count));
endmodule

bind trig_coinc_eval trig_coinc_eval_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .trig_out(trig_out), .trig_count(trig_count)
);

// File: tb/trig_coinc_eval_test.sv
module trig_coinc_eval_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [5:0]  ch_in = '0;
  logic [63:0] table_in = '0;
  logic        table_wr = 1'b0;
  logic        trig_out;
  logic [31:0] trig_count;

  int checks = 0;
  int errors = 0;
  logic [63:0] m_tbl = '0;
  logic        m_prev = 1'b0;
  logic [31:0] m_cnt = '0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  trig_coinc_eval uut (
    .clk(clk), .rst(rst), .enable(enable), .ch_in(ch_in),
    .table_in(table_in), .table_wr(table_wr),
    .trig_out(trig_out), .trig_count(trig_count)
  );

  function automatic logic [63:0] tbl_example();
    logic [63:0] t = '0;
    for (int i = 0; i < 64; i++)
      t[i] = i[0] & ~i[1] & (|i[5:2]);
    return t;
  endfunction

  function automatic logic [63:0] tbl_parity();
    logic [63:0] t = '0;
    for (int i = 0; i < 64; i++) t[i] = ^i[5:0];
    return t;
  endfunction

  function automatic logic [63:0] tbl_single(input int k);
    logic [63:0] t = '0;
    for (int i = 0; i < 64; i++) t[i] = i[k];
    return t;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [5:0] c, input logic e, input logic w,
                      input logic [63:0] t, input string req);
    logic exp_trig;
    ch_in = c; enable = e; table_wr = w; table_in = t;
    exp_trig = e & m_tbl[c] & ~m_prev;
    m_prev   = e & m_tbl[c];
    if (w) m_tbl = t;
    if (exp_trig) m_cnt = m_cnt + 1;
    @(posedge clk);
    @(negedge clk);
    table_wr = 1'b0;
    check({req, " strobe"}, {31'd0, trig_out}, {31'd0, exp_trig});
    check({req, " count"}, trig_count, m_cnt);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_tbl = '0; m_prev = 1'b0; m_cnt = '0;
    check("R1 strobe after reset", {31'd0, trig_out}, 32'd0);
    check("R1 count after reset", trig_count, 32'd0);
  endtask

  task automatic load(input logic [63:0] t);
    step(6'd0, 1'b1, 1'b1, t, "R5 load");
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 64; i++) begin
      step(6'd0, 1'b1, 1'b0, table_in, req);
      step(i[5:0], 1'b1, 1'b0, table_in, req);
    end
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R1: cleared table never fires
    for (int i = 0; i < 64; i++) step(i[5:0], 1'b1, 1'b0, '1, "R1 empty table");

    load(tbl_example());
    sweep("R7 veto example");
    load({1'b1, 63'd0});
    sweep("R2 all-channel AND");
    load(tbl_parity());
    sweep("R2 parity");

    // R8: channel 3 only; other channels toggle alone while held
    load(tbl_single(2));
    step(6'b000100, 1'b1, 1'b0, '0, "R8 ch3 rise");
    for (int i = 0; i < 64; i++) step(i[5:0] | 6'b000100, 1'b1, 1'b0, '0, "R8 dont-care held");
    step(6'b111011, 1'b1, 1'b0, '0, "R8 ch3 absent");
    for (int i = 0; i < 64; i++) step(i[5:0] & 6'b111011, 1'b1, 1'b0, '0, "R8 dont-care idle");

    // R3: Gray walk through true entries of the parity-complement-free table (all ones except 0)
    load(~64'd1);
    for (int i = 1; i < 64; i++) step(i[5:0] ^ (i[5:0] >> 1) | 6'd1, 1'b1, 1'b0, '0, "R3 sustained");
    for (int i = 0; i < 4; i++) step(6'h3f, 1'b1, 1'b0, '0, "R3 held");

    // R4: enable drop and re-arm
    for (int i = 0; i < 3; i++) step(6'h3f, 1'b0, 1'b0, '0, "R4 disabled");
    step(6'h3f, 1'b1, 1'b0, '0, "R4 re-enable fires");
    step(6'h3f, 1'b1, 1'b0, '0, "R4 no repeat");
    step(6'h00, 1'b0, 1'b0, '0, "R4 idle");

    // R5: table word changes without load have no effect
    load(64'd0);
    for (int i = 0; i < 8; i++) step(6'h15, 1'b1, 1'b0, '1, "R5 no load");
    // load edge uses old table, next cycle uses new
    step(6'h15, 1'b1, 1'b1, 64'd1 << 6'h15, "R5 load edge");
    step(6'h15, 1'b1, 1'b0, '0, "R5 after load");
    step(6'h15, 1'b1, 1'b0, '0, "R5 held");

    // R6/R1: count tally then synchronous reset mid-run
    check("R6 count tally", trig_count, m_cnt);
    do_reset();
    step(6'h15, 1'b1, 1'b0, '0, "R1 table cleared");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule